// File: doc/BRIEF.md
# Transfer Length Splitter for a Serial-Flash Command Queue

This block turns one byte count into the data command entries that a serial-flash command queue executes. The immediate field of one entry holds at most 255 bytes. Larger amounts are described by exponent entries, each of which moves 2^k bytes. The splitter receives a 32-bit count and a 20-bit template that already carries the lane-mode, direction, select and data-transfer bits. It then streams out entries that together cover exactly that count.

The count is broken down from its least significant side upward. While more than 255 bytes remain, the lowest set bit at position 8 or above becomes an exponent entry, and that power of two is removed from the remaining count. Whatever is left below 256 goes out as one final immediate entry. Entries leave on a valid/ready stream. A one-cycle done pulse marks the acceptance of the last entry. A new request is taken only while the splitter is idle, and a busy output shows that a breakdown is in progress.

Top module: `len_cmd_splitter`

## Requirements
- R1: A request is taken at a clock edge where `req_valid` is high and `busy` is low. For a non-zero count, `busy` is high from the next cycle until the last entry has been accepted.
- R2: A count from 1 to 255 gives exactly one entry, with bit 9 (the exponent flag) clear and bits 7:0 equal to the count.
- R3: While more than 255 bytes remain, each entry has bit 9 set and bits 7:0 equal to k, where k is the lowest set bit of the remaining count at position 8 or above. 2^k is then subtracted from the remaining count, so exponent values rise strictly within one sequence.
- R4: When the count is above 255 and its bits 7:0 are zero, the sequence ends with its last exponent entry; no entry with an immediate of zero is ever produced.
- R5: Every template bit except bits 7:0 and bit 9 (which include the data-transfer bit 8, the direction bits and the select bits) appears unchanged in every entry. Template bits 7:0 and 9 have no effect on any entry.
- R6: While `ent_valid` is high and `ent_ready` is low, `ent_valid` stays high and `ent_data` stays unchanged in the next cycle.
- R7: `done` is high for exactly one cycle, the cycle after the last entry is accepted. In that cycle `busy` and `ent_valid` are low.
- R8: A count of zero produces no entry. `busy` stays low, and `done` pulses in the cycle after the request is taken.
- R9: A `req_valid` that arrives while `busy` is high is ignored, and the sequence in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request strobe; taken only while idle |
| req_len | input | 32 | Byte count to be split |
| req_tmpl | input | 20 | Base command bits copied into every entry |
| busy | output | 1 | A breakdown is in progress |
| ent_valid | output | 1 | `ent_data` holds an entry |
| ent_ready | input | 1 | The command queue accepts the entry |
| ent_data | output | 20 | Command entry: bits 7:0 immediate, bit 9 exponent flag, other bits from the template |
| done | output | 1 | One-cycle pulse after the last entry is accepted |

## Verification
Two situations are hard to reach from the ports.

The first is a request that arrives while a sequence is still draining. The bench raises `req_valid` with a different count one cycle into a long sequence. It then checks that every remaining entry still matches the original count.

The second is back-pressure in the middle of a sequence, right where the remaining count is updated. Counts with many set high bits, such as all ones, are combined with a ready pattern that stalls two cycles out of three. This places stalls both before and after exponent entries and before the final immediate. The bench also checks that entries stay stable across each stall.

// File: rtl/spl_pkg.sv
package spl_pkg;
  // Field positions decoded by the command queue downstream.
  localparam int unsigned IMM_W   = 8;
  localparam int unsigned EXP_POS = 9;
  // Counts above this many bytes need exponent entries.
  localparam int unsigned IMM_MAX = (1 << IMM_W) - 1;

  typedef enum logic {
    SPL_IDLE = 1'b0,
    SPL_EMIT = 1'b1
  } spl_state_e;
endpackage

// File: rtl/spl_lowbit.sv
module spl_lowbit #(
  parameter int unsigned W     = 24,
  parameter int unsigned IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     vec,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  logic [W-1:0] seen;
  logic [W-1:0] first;

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_chain
      if (gi == 0) begin : g_lsb
        assign seen[gi]  = vec[gi];
        assign first[gi] = vec[gi];
      end else begin : g_up
        assign seen[gi]  = vec[gi] | seen[gi-1];
        assign first[gi] = vec[gi] & ~seen[gi-1];
      end
    end
  endgenerate

  assign any = seen[W-1];

  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (first[i]) idx = idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/spl_entry_fmt.sv
module spl_entry_fmt
  import spl_pkg::*;
#(
  parameter int unsigned ENT_W = 20,
  parameter int unsigned K_W   = 5
) (
  input  logic [ENT_W-1:0] tmpl,
  input  logic             is_exp,
  input  logic [K_W-1:0]   exp_k,
  input  logic [IMM_W-1:0] low_imm,
  output logic [ENT_W-1:0] entry
);
  localparam logic [ENT_W-1:0] IMM_MASK = ENT_W'(IMM_MAX);
  localparam logic [ENT_W-1:0] EXP_MASK = ENT_W'(1) << EXP_POS;
  localparam logic [ENT_W-1:0] KEEP     = ~(IMM_MASK | EXP_MASK);

  logic [ENT_W-1:0] len_code;

  always_comb begin
    if (is_exp) len_code = EXP_MASK | ENT_W'(exp_k);
    else        len_code = ENT_W'(low_imm);
    entry = (tmpl & KEEP) | len_code;
  end
endmodule

// File: rtl/len_cmd_splitter.sv
module len_cmd_splitter
  import spl_pkg::*;
#(
  parameter int unsigned LEN_W = 32,
  parameter int unsigned ENT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [LEN_W-1:0] req_len,
  input  logic [ENT_W-1:0] req_tmpl,
  output logic             busy,
  output logic             ent_valid,
  input  logic             ent_ready,
  output logic [ENT_W-1:0] ent_data,
  output logic             done
);
  localparam int unsigned HI_W  = LEN_W - IMM_W;
  localparam int unsigned HI_IW = (HI_W > 1) ? $clog2(HI_W) : 1;
  localparam int unsigned K_W   = $clog2(LEN_W);

  spl_state_e       state_q, state_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic [ENT_W-1:0] tmpl_q;
  logic             done_q, done_d;

  logic             accept, fire, last, rem_en, tmpl_en;
  logic             is_exp;
  logic [HI_IW-1:0] hi_idx;
  logic [K_W-1:0]   exp_k;
  logic [LEN_W-1:0] rem_after;

  // Lowest set bit at or above the immediate boundary
  spl_lowbit #(.W(HI_W), .IDX_W(HI_IW)) lowbit_i (
    .vec (rem_q[LEN_W-1:IMM_W]),
    .idx (hi_idx),
    .any (is_exp)
  );

  assign exp_k = K_W'(hi_idx) + K_W'(IMM_W);

  spl_entry_fmt #(.ENT_W(ENT_W), .K_W(K_W)) fmt_i (
    .tmpl    (tmpl_q),
    .is_exp  (is_exp),
    .exp_k   (exp_k),
    .low_imm (rem_q[IMM_W-1:0]),
    .entry   (ent_data)
  );

  // Next-state logic
  always_comb begin
    accept    = req_valid && (state_q == SPL_IDLE);
    fire      = (state_q == SPL_EMIT) && ent_ready;
    rem_after = is_exp ? (rem_q & ~(LEN_W'(1) << exp_k)) : '0;
    last      = fire && (rem_after == '0);
    rem_en    = accept || fire;
    tmpl_en   = accept;

    state_d = state_q;
    if (accept) begin
      state_d = (req_len != '0) ? SPL_EMIT : SPL_IDLE;
    end else if (last) begin
      state_d = SPL_IDLE;
    end

    rem_d = rem_q;
    if (accept)    rem_d = req_len;
    else if (fire) rem_d = rem_after;

    done_d = (accept && (req_len == '0)) || last;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SPL_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (rem_en) begin
      rem_q <= rem_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmpl_q <= '0;
    end else if (tmpl_en) begin
      tmpl_q <= req_tmpl;
    end
  end

  assign busy      = (state_q == SPL_EMIT);
  assign ent_valid = (state_q == SPL_EMIT);
  assign done      = done_q;

  // Assertions
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid && !ent_ready) |=> (ent_valid && $stable(ent_data)));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !ent_valid));

  assert_exp_rising_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid && ent_ready && ent_data[EXP_POS]) |=>
      (!ent_valid || !ent_data[EXP_POS] ||
       (ent_data[IMM_W-1:0] > $past(ent_data[IMM_W-1:0]))));

  assert_exp_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid && ent_data[EXP_POS]) |->
      ((ent_data[IMM_W-1:0] >= IMM_W) && (ent_data[IMM_W-1:0] < LEN_W)));

  assert_no_zero_imm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid && !ent_data[EXP_POS]) |-> (ent_data[IMM_W-1:0] != '0));

  assert_busy_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rem_q != '0));

  assert_busy_ignores_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ent_ready) |=> $stable(rem_q));
endmodule

// File: tb/len_cmd_splitter_tb_top.sv
module len_cmd_splitter_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [19:0] KEEP = 20'hFFD00;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_len;
  logic [19:0] req_tmpl;
  logic        busy, ent_valid, ent_ready, done;
  logic [19:0] ent_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  len_cmd_splitter dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_len(req_len),
    .req_tmpl(req_tmpl), .busy(busy), .ent_valid(ent_valid),
    .ent_ready(ent_ready), .ent_data(ent_data), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  function automatic int low_k(input logic [31:0] r);
    for (int i = 8; i < 32; i++) if (r[i]) return i;
    return -1;
  endfunction

  function automatic logic [19:0] model_entry(input logic [31:0] r, input logic [19:0] t);
    if (r > 32'd255) return (t & KEEP) | 20'h200 | 20'(low_k(r));
    return (t & KEEP) | 20'(r[7:0]);
  endfunction

  function automatic logic [31:0] model_next(input logic [31:0] r);
    if (r > 32'd255) return r & ~(32'd1 << low_k(r));
    return 32'd0;
  endfunction

  task automatic run_case(input logic [31:0] len, input logic [19:0] tmpl,
                          input bit stall, input bit poke, input string tag);
    logic [31:0] r;
    logic [19:0] prev;
    bit hold, fin;
    @(negedge clk);
    req_valid = 1'b1; req_len = len; req_tmpl = tmpl; ent_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    if (len == 32'd0) begin
      chk(done && !busy && !ent_valid, "R8 zero count done/no entry",
          {busy, ent_valid, done}, 3'b001);
      @(negedge clk);
      chk(!done && !ent_valid, "R8/R7 zero count single pulse", {ent_valid, done}, 0);
      return;
    end
    chk(busy && ent_valid, "R1 busy after accept", {busy, ent_valid}, 2'b11);
    r = len; hold = 1'b0; fin = 1'b0;
    for (int c = 0; c < 400 && !fin; c++) begin
      if (poke && c == 1) begin req_valid = 1'b1; req_len = 32'h0000_0005; end
      else req_valid = 1'b0;
      ent_ready = stall ? ((c % 3) == 2) : 1'b1;
      if (hold) chk(ent_valid && ent_data == prev, "R6 stable under stall",
                    {11'd0, ent_valid, ent_data}, {12'h001, prev});
      hold = 1'b0;
      if (ent_valid) begin
        if (!ent_ready) begin
          hold = 1'b1; prev = ent_data;
        end else begin
          chk(ent_data == model_entry(r, tmpl),
              {tag, (r > 32'd255) ? " R3 exp entry" : " R2 imm entry", " R5 template"},
              ent_data, model_entry(r, tmpl));
          r = model_next(r);
          if (r == 32'd0) fin = 1'b1;
        end
      end
      @(negedge clk);
    end
    req_valid = 1'b0; ent_ready = 1'b0;
    chk(fin, {tag, " R3 sequence completes"}, fin, 1);
    chk(done && !busy && !ent_valid, {tag, " R7 done after last entry, R4 no extra entry"},
        {busy, ent_valid, done}, 3'b001);
    @(negedge clk);
    chk(!done && !busy, {tag, " R7 done single cycle"}, {busy, done}, 0);
  endtask

  task automatic t_reset;
    chk(!busy && !ent_valid && !done, "R1 reset idle", {busy, ent_valid, done}, 0);
  endtask

  task automatic t_zero;     run_case(32'd0, 20'h12345, 1'b0, 1'b0, "R8"); endtask
  task automatic t_small;
    run_case(32'd1,   20'h5A1FF, 1'b0, 1'b0, "R2 len1");
    run_case(32'd255, 20'hFFFFF, 1'b0, 1'b0, "R2 len255");
  endtask
  task automatic t_pow2;
    run_case(32'd256,       20'h1C3FF, 1'b0, 1'b0, "R4 len256");
    run_case(32'h8000_0000, 20'h30100, 1'b0, 1'b0, "R4 top bit");
  endtask
  task automatic t_mixed;
    run_case(32'h0000_0317, 20'h2A200, 1'b0, 1'b0, "R3 mixed");
    run_case(32'hFFFF_FFFF, 20'h0C1AA, 1'b0, 1'b0, "R3 all ones");
  endtask
  task automatic t_stall;
    run_case(32'hFFFF_FFFF, 20'h4D155, 1'b1, 1'b0, "R6 all ones stalled");
    run_case(32'h1234_5678, 20'h3F0F0, 1'b1, 1'b0, "R6 pattern stalled");
  endtask
  task automatic t_busy_req; run_case(32'h00F0_0F01, 20'h11100, 1'b0, 1'b1, "R9 request while busy"); endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_len = '0; req_tmpl = '0; ent_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero();
    t_small();
    t_pow2();
    t_mixed();
    t_stall();
    t_busy_req();
    t_zero();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog R1 run hung actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule